// File: doc/BRIEF.md
# Extended UART Interrupt Identification Unit

This block sits beside the data path of a FIFO-based UART. It gathers the events and levels that call for software attention, masks them with an 8-bit interrupt-enable register, and presents the most urgent unmasked one as an 8-bit identification code. It also drives an active-low interrupt line. Three sources are sticky inside the block: line-status error, transmit space and modem change. Each is set by a one-cycle event pulse and stays set until its own acknowledge. The remaining sources are levels that the surrounding logic holds until the cause is gone: receive trigger, receive timeout, GPIO change, XOFF received, RTS change and CTS change.

Software reaches the block through a small register port. Address 0 is the enable register, which can be read and written. Address 1 is the identification register, which can only be read. The upper four enable bits control the enhanced sources and the sleep request. They accept writes only while the enhanced-mode input is high, so a driver that knows only the classic four sources cannot switch them on by accident.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset the identification value is 0x01, `irq_n` is 1 and the enable register reads 0x00.
- R2: Bit 0 of the identification value is 0 while any enabled source is pending and 1 otherwise. The idle value is 0x01, and `irq_n` always equals bit 0.
- R3: Source codes are: line-status error 0x06, receive timeout 0x0C, receive data 0x04, transmit space 0x02, modem change 0x00, GPIO change 0x30, XOFF 0x10, RTS/CTS change 0x20.
- R4: When several sources are pending, the code shown follows this fixed order, highest first: line-status, timeout, receive data, transmit space, modem, GPIO, XOFF, RTS/CTS.
- R5: The enable bits gate the sources as follows: bit 0 gates receive data and timeout, bit 1 transmit space, bit 2 line-status, bit 3 modem and GPIO, bit 5 XOFF, bit 6 RTS change, bit 7 CTS change. Bit 4 is the sleep request and gates no source. A source whose enable bit is 0 never appears in the code.
- R6: Writes to address 0 always update enable bits 3:0. They update bits 7:4 only while `enh_mode` is 1; otherwise those bits keep their value. Address 0 reads back the enable register. Writes to address 1 have no effect.
- R7: A pulse on `tx_space_evt` latches transmit space. It is cleared by a read of address 1 while the code 0x02 is shown. A read while another code is shown leaves it pending.
- R8: A pulse on `ls_err_evt` latches line-status error until an `lsr_rd` strobe.
- R9: A pulse on `modem_evt` latches modem change until an `msr_rd` strobe.
- R10: A change of any source input, strobe or enable write sampled at a clock edge shows in the identification value and `irq_n` right after that same edge.
- R11: The level sources (receive trigger, timeout, GPIO, XOFF, RTS, CTS) follow their inputs and are not latched.
- R12: When a set event and its clear arrive in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enh_mode | input | 1 | Enhanced mode; unlocks enable bits 7:4 |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (acknowledges on address 1) |
| reg_addr | input | 1 | 0 = enable register, 1 = identification register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| lsr_rd | input | 1 | Line-status register read strobe |
| msr_rd | input | 1 | Modem-status register read strobe |
| rx_trig | input | 1 | Receive FIFO at trigger level (level) |
| rx_tmo | input | 1 | Receive timeout (level) |
| tx_space_evt | input | 1 | Transmit space event (pulse) |
| ls_err_evt | input | 1 | Line-status error event (pulse) |
| modem_evt | input | 1 | Modem input change event (pulse) |
| gpio_chg | input | 1 | GPIO pin change (level) |
| xoff_rcv | input | 1 | XOFF received (level) |
| rts_chg | input | 1 | RTS change (level) |
| cts_chg | input | 1 | CTS change (level) |
| ident | output | 8 | Identification value |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The bench raises every source at once and removes them one by one. Each step must expose the next code in the fixed order, so a swapped priority or a wrong code shows up at a specific step. It reads the identification register while a higher code hides transmit space; a design that clears on every read would lose that interrupt. It writes all ones with enhanced mode off and then all zeros, which catches enhanced enable bits that are not locked, and also a lock that freezes the low bits as well. It checks the code and the interrupt line right after the edge where a source or enable changes, which exposes any extra pipeline stage. It also pulses an event together with its acknowledge, which exposes a clear that wins over a set.

// File: rtl/uart_irq_pkg.sv
// Shared constants for the UART interrupt identification unit.
// Source indices double as priority rank: index 0 is the highest priority.
package uart_irq_pkg;
    localparam int ID_W = 8;
    localparam int EN_W = 8;
    localparam int NSRC = 8;
    localparam int NLAT = 3;

    localparam logic [ID_W-1:0] ID_IDLE = 8'h01;
    localparam logic [ID_W-1:0] ID_TX   = 8'h02;

    // Sources in priority order
    localparam int S_LS   = 0;
    localparam int S_TMO  = 1;
    localparam int S_RX   = 2;
    localparam int S_TX   = 3;
    localparam int S_MDM  = 4;
    localparam int S_GPIO = 5;
    localparam int S_XOFF = 6;
    localparam int S_FLOW = 7;

    // Enable register bit positions
    localparam int EN_RX   = 0;
    localparam int EN_TX   = 1;
    localparam int EN_LS   = 2;
    localparam int EN_MS   = 3;
    localparam int EN_XOFF = 5;
    localparam int EN_RTS  = 6;
    localparam int EN_CTS  = 7;
    localparam int EN_LOCK_LO = 4;   // bits at or above this need enhanced mode

    // Sticky latch indices
    localparam int L_LS  = 0;
    localparam int L_TX  = 1;
    localparam int L_MDM = 2;

    // Identification code for a source index
    function automatic logic [ID_W-1:0] src_code(input int idx);
        case (idx)
            S_LS:    return 8'h06;
            S_TMO:   return 8'h0C;
            S_RX:    return 8'h04;
            S_TX:    return 8'h02;
            S_MDM:   return 8'h00;
            S_GPIO:  return 8'h30;
            S_XOFF:  return 8'h10;
            default: return 8'h20;
        endcase
    endfunction
endpackage

// File: rtl/uart_irq_ier.sv
// Interrupt-enable register with a write lock on its upper bits.
// Assumes: bits at or above LOCK_LO take writes only while enh is high.
// Exposes the next value so downstream logic reacts in the write cycle.
module uart_irq_ier #(
    parameter int W       = 8,
    parameter int LOCK_LO = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enh,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q,
    output logic [W-1:0] nxt
);
    // Merge write data per bit, honouring the enhanced lock
    always_comb begin
        nxt = q;
        if (wr) begin
            for (int i = 0; i < W; i++) begin
                if (i < LOCK_LO || enh) nxt[i] = wdata[i];
            end
        end
    end

    // Hold the register
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= nxt;
    end
endmodule

// File: rtl/uart_irq_sticky.sv
// Bank of set/clear flags for event-type interrupt sources.
// Assumes: set has priority over clear in the same cycle.
module uart_irq_sticky #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] q,
    output logic [N-1:0] nxt
);
    for (genvar g = 0; g < N; g++) begin : g_flag
        // Next state of one flag
        always_comb nxt[g] = set[g] | (q[g] & ~clr[g]);

        // Flag storage
        always_ff @(posedge clk) begin
            if (!rst_n) q[g] <= 1'b0;
            else        q[g] <= nxt[g];
        end
    end
endmodule

// File: rtl/uart_irq_prio.sv
// Fixed-priority encoder from active-source vector to identification code.
// Assumes: index 0 is the highest priority; no active source yields the idle code.
module uart_irq_prio
    import uart_irq_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic [N-1:0]    act,
    output logic [ID_W-1:0] code
);
    // Scan from lowest to highest priority; the last hit wins
    always_comb begin
        code = ID_IDLE;
        for (int i = N - 1; i >= 0; i--) begin
            if (act[i]) code = src_code(i);
        end
    end
endmodule

// File: rtl/uart_irq_ident.sv
// UART interrupt identification unit: masks sources, ranks them and
// registers the winning code; irq_n is bit 0 of that code.
// Assumes: event inputs are one-cycle pulses, level inputs are held by
// their owners until serviced; reg_rd on address 1 acknowledges TX space.
module uart_irq_ident
    import uart_irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enh_mode,
    input  logic            reg_wr,
    input  logic            reg_rd,
    input  logic            reg_addr,
    input  logic [EN_W-1:0] reg_wdata,
    output logic [EN_W-1:0] reg_rdata,
    input  logic            lsr_rd,
    input  logic            msr_rd,
    input  logic            rx_trig,
    input  logic            rx_tmo,
    input  logic            tx_space_evt,
    input  logic            ls_err_evt,
    input  logic            modem_evt,
    input  logic            gpio_chg,
    input  logic            xoff_rcv,
    input  logic            rts_chg,
    input  logic            cts_chg,
    output logic [ID_W-1:0] ident,
    output logic            irq_n
);
    logic [EN_W-1:0] ier_q, ier_nxt;
    logic [NLAT-1:0] lat_set, lat_clr, lat_q, lat_nxt;
    logic [NSRC-1:0] act;
    logic [ID_W-1:0] code_nxt, ident_q;
    logic            ls_pend, tx_pend, md_pend;

    uart_irq_ier #(.W(EN_W), .LOCK_LO(EN_LOCK_LO)) u_ier (
        .clk(clk), .rst_n(rst_n), .enh(enh_mode),
        .wr(reg_wr && !reg_addr), .wdata(reg_wdata),
        .q(ier_q), .nxt(ier_nxt)
    );

    // Set and clear terms of the sticky sources
    always_comb begin
        lat_set        = '0;
        lat_clr        = '0;
        lat_set[L_LS]  = ls_err_evt;
        lat_set[L_TX]  = tx_space_evt;
        lat_set[L_MDM] = modem_evt;
        lat_clr[L_LS]  = lsr_rd;
        lat_clr[L_TX]  = reg_rd && reg_addr && (ident_q == ID_TX);
        lat_clr[L_MDM] = msr_rd;
    end

    uart_irq_sticky #(.N(NLAT)) u_sticky (
        .clk(clk), .rst_n(rst_n), .set(lat_set), .clr(lat_clr),
        .q(lat_q), .nxt(lat_nxt)
    );

    // Mask next-cycle source state with the next enable value
    always_comb begin
        act         = '0;
        act[S_LS]   = lat_nxt[L_LS]  & ier_nxt[EN_LS];
        act[S_TMO]  = rx_tmo         & ier_nxt[EN_RX];
        act[S_RX]   = rx_trig        & ier_nxt[EN_RX];
        act[S_TX]   = lat_nxt[L_TX]  & ier_nxt[EN_TX];
        act[S_MDM]  = lat_nxt[L_MDM] & ier_nxt[EN_MS];
        act[S_GPIO] = gpio_chg       & ier_nxt[EN_MS];
        act[S_XOFF] = xoff_rcv       & ier_nxt[EN_XOFF];
        act[S_FLOW] = (rts_chg & ier_nxt[EN_RTS]) | (cts_chg & ier_nxt[EN_CTS]);
    end

    uart_irq_prio #(.N(NSRC)) u_prio (.act(act), .code(code_nxt));

    // Register the identification value
    always_ff @(posedge clk) begin
        if (!rst_n) ident_q <= ID_IDLE;
        else        ident_q <= code_nxt;
    end

    // Outputs and read mux
    always_comb begin
        ident     = ident_q;
        irq_n     = ident_q[0];
        reg_rdata = reg_addr ? ident_q : ier_q;
        ls_pend   = lat_q[L_LS];
        tx_pend   = lat_q[L_TX];
        md_pend   = lat_q[L_MDM];
    end
endmodule

// File: rtl/uart_irq_ident_chk.sv
// Property checker for uart_irq_ident, attached by bind below.
module uart_irq_ident_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       enh_mode,
    input logic       reg_wr,
    input logic       reg_rd,
    input logic       reg_addr,
    input logic       lsr_rd,
    input logic       msr_rd,
    input logic       tx_space_evt,
    input logic       ls_err_evt,
    input logic       modem_evt,
    input logic [7:0] ident,
    input logic       irq_n,
    input logic [7:0] ier_q,
    input logic       ls_pend,
    input logic       tx_pend,
    input logic       md_pend
);
    AST_MASKED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ier_q == 8'h00 && !reg_wr) |=> (ident == 8'h01 && irq_n)); // R5

    AST_ENH_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (!enh_mode && reg_wr && !reg_addr) |=> (ier_q[7:4] == $past(ier_q[7:4]))); // R6

    AST_LS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ls_pend && !lsr_rd) |=> ls_pend); // R8

    AST_MDM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (md_pend && !msr_rd) |=> md_pend); // R9

    AST_TX_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr && ident == 8'h02 && !tx_space_evt) |=> !tx_pend); // R7

    AST_LS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (ls_pend && ier_q[2] && !lsr_rd && !reg_wr) |=> (ident == 8'h06)); // R4

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (ls_err_evt && lsr_rd) |=> ls_pend); // R12
endmodule

bind uart_irq_ident uart_irq_ident_chk chk_i (
    .clk(clk), .rst_n(rst_n), .enh_mode(enh_mode), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_addr(reg_addr), .lsr_rd(lsr_rd), .msr_rd(msr_rd),
    .tx_space_evt(tx_space_evt), .ls_err_evt(ls_err_evt), .modem_evt(modem_evt),
    .ident(ident), .irq_n(irq_n), .ier_q(ier_q), .ls_pend(ls_pend),
    .tx_pend(tx_pend), .md_pend(md_pend)
);

// File: tb/uart_irq_ident_tb_top.sv
`timescale 1ns/1ps
module uart_irq_ident_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enh_mode = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0, reg_addr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       lsr_rd = 1'b0, msr_rd = 1'b0;
    logic       rx_trig = 1'b0, rx_tmo = 1'b0, tx_space_evt = 1'b0;
    logic       ls_err_evt = 1'b0, modem_evt = 1'b0, gpio_chg = 1'b0;
    logic       xoff_rcv = 1'b0, rts_chg = 1'b0, cts_chg = 1'b0;
    logic [7:0] ident;
    logic       irq_n;
    int         total = 0;
    int         bad = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    uart_irq_ident dut_i (.*);

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // Check code and that irq_n mirrors bit 0
    task automatic chk_id(input string req, input logic [7:0] exp);
        chk(req, ident, exp);
        chk({req, " irq_n"}, {7'd0, irq_n}, {7'd0, exp[0]});
    endtask

    task automatic wr_ier(input logic [7:0] v);
        reg_addr = 1'b0; reg_wdata = v; reg_wr = 1'b1;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic rd_ier(input string req, input logic [7:0] exp);
        reg_addr = 1'b0;
        #0.5;
        chk(req, reg_rdata, exp);
    endtask

    task automatic rd_ident(input string req, input logic [7:0] exp);
        reg_addr = 1'b1; reg_rd = 1'b1;
        #0.5;
        chk(req, reg_rdata, exp);
        tick();
        reg_rd = 1'b0;
    endtask

    task automatic t_reset();
        chk_id("R1 reset ident", 8'h01);
        rd_ier("R1 reset ier", 8'h00);
    endtask

    task automatic t_enh_lock();
        enh_mode = 1'b0;
        wr_ier(8'hFF);
        rd_ier("R6 locked high bits", 8'h0F);
        enh_mode = 1'b1;
        wr_ier(8'hFF);
        rd_ier("R6 unlocked write", 8'hFF);
        enh_mode = 1'b0;
        wr_ier(8'h00);
        rd_ier("R6 low bits always written", 8'hF0);
        reg_addr = 1'b1; reg_wdata = 8'h00; reg_wr = 1'b1;
        tick();
        reg_wr = 1'b0;
        rd_ier("R6 ident address write ignored", 8'hF0);
        enh_mode = 1'b1;
        wr_ier(8'h00);
        rd_ier("R6 cleared", 8'h00);
    endtask

    task automatic t_mask_latency();
        rx_trig = 1'b1;
        tick();
        chk_id("R5 rx masked", 8'h01);
        wr_ier(8'h01);
        chk_id("R10 enable write same edge", 8'h04);
        rx_trig = 1'b0;
        tick();
        chk_id("R11 rx level dropped", 8'h01);
        rx_trig = 1'b1;
        tick();
        chk_id("R10 rx rise same edge", 8'h04);
        rx_trig = 1'b0;
        wr_ier(8'h00);
        chk_id("R2 idle", 8'h01);
    endtask

    task automatic t_priority();
        enh_mode = 1'b1;
        wr_ier(8'hEF);
        ls_err_evt = 1'b1; tx_space_evt = 1'b1; modem_evt = 1'b1;
        rx_tmo = 1'b1; rx_trig = 1'b1; gpio_chg = 1'b1; xoff_rcv = 1'b1; cts_chg = 1'b1;
        tick();
        ls_err_evt = 1'b0; tx_space_evt = 1'b0; modem_evt = 1'b0;
        chk_id("R4 line status first", 8'h06);
        tick();
        chk_id("R8 line status holds", 8'h06);
        lsr_rd = 1'b1; tick(); lsr_rd = 1'b0;
        chk_id("R4 timeout next", 8'h0C);
        rx_tmo = 1'b0; tick();
        chk_id("R4 rx data next", 8'h04);
        rx_trig = 1'b0; tick();
        chk_id("R4 tx next", 8'h02);
        rd_ident("R7 read shows tx", 8'h02);
        chk_id("R3 modem code", 8'h00);
        tick();
        chk_id("R9 modem holds", 8'h00);
        msr_rd = 1'b1; tick(); msr_rd = 1'b0;
        chk_id("R3 gpio code", 8'h30);
        gpio_chg = 1'b0; tick();
        chk_id("R3 xoff code", 8'h10);
        xoff_rcv = 1'b0; tick();
        chk_id("R3 cts code", 8'h20);
        cts_chg = 1'b0; tick();
        chk_id("R11 all clear", 8'h01);
    endtask

    task automatic t_tx_hidden();
        wr_ier(8'h03);
        rx_trig = 1'b1; tx_space_evt = 1'b1;
        tick();
        tx_space_evt = 1'b0;
        chk_id("R7 rx hides tx", 8'h04);
        rd_ident("R7 read shows rx", 8'h04);
        rx_trig = 1'b0;
        tick();
        chk_id("R7 tx survived read", 8'h02);
        rd_ident("R7 read shows tx", 8'h02);
        chk_id("R7 tx cleared", 8'h01);
    endtask

    task automatic t_set_wins();
        wr_ier(8'h04);
        ls_err_evt = 1'b1; lsr_rd = 1'b1;
        tick();
        ls_err_evt = 1'b0; lsr_rd = 1'b0;
        chk_id("R12 set beats clear", 8'h06);
        lsr_rd = 1'b1; tick(); lsr_rd = 1'b0;
        chk_id("R8 cleared by lsr read", 8'h01);
    endtask

    task automatic t_flow_enables();
        enh_mode = 1'b1;
        wr_ier(8'h40);
        rts_chg = 1'b1; tick();
        chk_id("R5 rts enabled", 8'h20);
        wr_ier(8'h80);
        chk_id("R5 rts masked by bit 6", 8'h01);
        cts_chg = 1'b1; tick();
        chk_id("R5 cts enabled by bit 7", 8'h20);
        rts_chg = 1'b0; cts_chg = 1'b0;
        wr_ier(8'h10);
        gpio_chg = 1'b1; xoff_rcv = 1'b1; tick();
        chk_id("R5 sleep bit gates nothing", 8'h01);
        wr_ier(8'h08);
        chk_id("R5 gpio under bit 3", 8'h30);
        gpio_chg = 1'b0; xoff_rcv = 1'b0;
        wr_ier(8'h00);
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_enh_lock();
        t_mask_latency();
        t_priority();
        t_tx_hidden();
        t_set_wins();
        t_flow_enables();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule